// File: doc/BRIEF.md
# Mode-Gated Loopback Test Sequencer

This block runs a self-contained loopback test through a parallel I/O PHY. On a start pulse it captures a direction mode and a calibration enable, then walks a fixed sequence of phases: idle, calibration handshake, write test, read test and a final finished phase. Any test phase that the captured configuration does not need is passed over, so the path through the sequence changes with the configuration.

In the write test the block sends pseudo-random bits into the core side of the PHY and checks what emerges on the pin side. The read test runs the other way: pattern bits are driven toward the pins, a read enable is raised for each burst, and the bits are checked when the PHY marks its core-side read data as valid. One pattern generator and one self-synchronising checker serve both directions. Each wrong bit is counted, and at the end a pass flag reports a clean run.

The calibration phase is a request/acknowledge stub with a bounded wait. An acknowledge that never comes marks the run as failed and does not stall it.

Top module: `loopback_seq`

## Requirements
- R1: Phases are coded idle=0, calibration=1, write=2, read=3, finished=4 on `state_o`. Within a run the code never decreases, and every run ends in finished (4).
- R2: The calibration phase is entered only when `cfg_reconf` was 1 at start. Otherwise it is passed over.
- R3: `cfg_mode` codes are 00 input-only, 01 output-only, 10 bidirectional; 11 behaves like 10. The write phase runs for every code except 00.
- R4: The read phase runs for every code except 01.
- R5: Each test phase runs BURSTS bursts (default 8) of BURST_LEN beats (default 16). A write beat is a cycle with `core_oe`=1 and a read beat is a cycle with `rdata_en`=1. The next burst starts only after all beats of the current one have come back (`pin_wvalid` for write, `rdata_valid` for read).
- R6: The pattern is PRBS-7 (x^7+x^6+1: each bit is the XOR of the bits sent 7 and 6 beats earlier) with a nonzero seed. The checker takes the first 7 returned bits of each test phase as its state and compares every later bit. Each mismatch adds 1 to `err_cnt` (16 bits, saturating) and sets `fail`.
- R7: In calibration `cal_req` stays high until `cal_ack`. Without an acknowledge the phase lasts exactly CAL_TIMEOUT cycles (default 1024), then sets `fail` and moves on to the next enabled phase.
- R8: `done` is high only in finished. `pass` is high only in finished with `err_cnt`=0 and `fail`=0.
- R9: `start` is taken only in idle or finished, where it captures the configuration and clears `err_cnt` and `fail`. While a run is in progress it is ignored.
- R10: The synchronous active-high `rst` returns the block to idle with `err_cnt`=0, `fail`=0 and no request or beat outputs active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Starts a run from idle or finished |
| cfg_mode | input | 2 | Direction mode, captured at start |
| cfg_reconf | input | 1 | Calibration enable, captured at start |
| cal_req | output | 1 | Calibration request |
| cal_ack | input | 1 | Calibration acknowledge |
| core_wdata | output | 1 | Write pattern bit toward the PHY core side |
| core_oe | output | 1 | Write beat strobe |
| pin_wdata | input | 1 | Write bit seen at the pins |
| pin_wvalid | input | 1 | Pin-side write bit valid |
| pin_rdata | output | 1 | Read pattern bit driven toward the pins |
| rdata_en | output | 1 | Read enable for the current burst |
| core_rdata | input | 1 | Read bit returned on the core side |
| rdata_valid | input | 1 | Core-side read bit valid |
| state_o | output | 3 | Current phase code |
| done | output | 1 | Run finished |
| pass | output | 1 | Run finished clean |
| fail | output | 1 | Sticky failure flag |
| err_cnt | output | 16 | Mismatched-bit count |

## Verification
The sequence is run with all four mode codes, with and without calibration, and with the acknowledge present or missing. The visited-phase set separates correct skipping from wrong skipping, and the timeout case shows the exact wait length. Single flipped bits are placed in the write stream, in the read stream and in the read half of a bidirectional run, and an exact count of 1 shows that the checker stays in sync after an error instead of spreading it. A start pulse in the middle of a run with a different configuration shows whether the captured configuration holds.

// File: rtl/loopback_seq.sv
module loopback_seq #(
  parameter int BURSTS      = 8,
  parameter int BURST_LEN   = 16,
  parameter int CAL_TIMEOUT = 1024,
  parameter int ERR_W       = 16,
  parameter logic [6:0] SEED = 7'h01
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [1:0]       cfg_mode,
  input  logic             cfg_reconf,
  output logic             cal_req,
  input  logic             cal_ack,
  output logic             core_wdata,
  output logic             core_oe,
  input  logic             pin_wdata,
  input  logic             pin_wvalid,
  output logic             pin_rdata,
  output logic             rdata_en,
  input  logic             core_rdata,
  input  logic             rdata_valid,
  output logic [2:0]       state_o,
  output logic             done,
  output logic             pass,
  output logic             fail,
  output logic [ERR_W-1:0] err_cnt
);
  localparam int LW = $clog2(BURST_LEN + 1);
  localparam int BW = (BURSTS > 1) ? $clog2(BURSTS) : 1;
  localparam int TW = (CAL_TIMEOUT > 1) ? $clog2(CAL_TIMEOUT) : 1;

  typedef enum logic [2:0] {S_INIT = 3'd0, S_CAL = 3'd1, S_WR = 3'd2, S_RD = 3'd3, S_DONE = 3'd4} st_t;

  st_t state;
  logic [1:0]    mode_q;
  logic          rc_q;
  logic [LW-1:0] tx_cnt, rx_cnt;
  logic [BW-1:0] bcnt;
  logic [TW-1:0] timer;
  logic [6:0]    gen, chk;
  logic [2:0]    sync;

  function automatic st_t next_of(st_t cur, logic [1:0] m, logic rc);
    if (cur < S_CAL && rc)         return S_CAL;
    if (cur < S_WR && m != 2'b00)  return S_WR;
    if (cur < S_RD && m != 2'b01)  return S_RD;
    return S_DONE;
  endfunction

  wire testing   = (state == S_WR) || (state == S_RD);
  wire tx_act    = testing && (tx_cnt != LW'(BURST_LEN));
  wire gen_bit   = gen[6] ^ gen[5];
  wire rx_v      = (state == S_WR) ? pin_wvalid : (state == S_RD) ? rdata_valid : 1'b0;
  wire rx_d      = (state == S_WR) ? pin_wdata  : core_rdata;
  wire synced    = (sync == 3'd7);
  wire exp_bit   = chk[6] ^ chk[5];
  wire mism      = rx_v && synced && (rx_d != exp_bit);
  wire burst_end = rx_v && (rx_cnt == LW'(BURST_LEN - 1));
  wire last      = burst_end && (bcnt == BW'(BURSTS - 1));

  assign cal_req    = (state == S_CAL);
  assign core_oe    = (state == S_WR) && tx_act;
  assign rdata_en   = (state == S_RD) && tx_act;
  assign core_wdata = gen_bit;
  assign pin_rdata  = gen_bit;
  assign state_o    = state;
  assign done       = (state == S_DONE);
  assign pass       = done && (err_cnt == '0) && !fail;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_INIT; mode_q <= '0; rc_q <= 1'b0;
      tx_cnt <= '0; rx_cnt <= '0; bcnt <= '0; timer <= '0;
      gen <= SEED; chk <= '0; sync <= '0;
      err_cnt <= '0; fail <= 1'b0;
    end else begin
      case (state)
        S_INIT, S_DONE: if (start) begin
          mode_q <= cfg_mode; rc_q <= cfg_reconf;
          err_cnt <= '0; fail <= 1'b0;
          tx_cnt <= '0; rx_cnt <= '0; bcnt <= '0; timer <= '0; sync <= '0;
          state <= next_of(S_INIT, cfg_mode, cfg_reconf);
        end
        S_CAL: begin
          if (cal_ack) begin
            timer <= '0;
            state <= next_of(S_CAL, mode_q, rc_q);
          end else if (timer == TW'(CAL_TIMEOUT - 1)) begin
            timer <= '0;
            fail  <= 1'b1;
            state <= next_of(S_CAL, mode_q, rc_q);
          end else begin
            timer <= timer + 1'b1;
          end
        end
        default: begin
          if (tx_act) begin
            gen    <= {gen[5:0], gen_bit};
            tx_cnt <= tx_cnt + 1'b1;
          end
          if (rx_v) begin
            chk    <= {chk[5:0], synced ? exp_bit : rx_d};
            rx_cnt <= rx_cnt + 1'b1;
            if (!synced) sync <= sync + 1'b1;
          end
          if (mism) begin
            fail <= 1'b1;
            if (err_cnt != '1) err_cnt <= err_cnt + 1'b1;
          end
          if (burst_end) begin
            rx_cnt <= '0;
            tx_cnt <= '0;
            bcnt   <= bcnt + 1'b1;
          end
          if (last) begin
            bcnt  <= '0;
            sync  <= '0;
            state <= next_of(state, mode_q, rc_q);
          end
        end
      endcase
    end
  end

  a_r1_forward: assert property (@(posedge clk) disable iff (rst)
    (state != S_INIT && state != S_DONE) |=> (state >= $past(state)));
  a_r2_cal_gated: assert property (@(posedge clk) disable iff (rst)
    (state == S_CAL) |-> rc_q);
  a_r3_write_gated: assert property (@(posedge clk) disable iff (rst)
    core_oe |-> (mode_q != 2'b00));
  a_r4_read_gated: assert property (@(posedge clk) disable iff (rst)
    rdata_en |-> (mode_q != 2'b01));
  a_r6_err_sets_fail: assert property (@(posedge clk) disable iff (rst)
    (err_cnt != '0) |-> fail);
  a_r7_ack_leaves: assert property (@(posedge clk) disable iff (rst)
    (cal_req && cal_ack) |=> !cal_req);
  a_r8_pass_clean: assert property (@(posedge clk) disable iff (rst)
    pass |-> (done && err_cnt == '0 && !fail));
  a_r9_start_ignored: assert property (@(posedge clk) disable iff (rst)
    (start && testing) |=> (mode_q == $past(mode_q)));
endmodule

// File: tb/loopback_seq_bench.sv
module loopback_seq_bench;
  localparam int BURSTS = 8, BURST_LEN = 16, CAL_TIMEOUT = 1024;
  localparam int BEATS = BURSTS * BURST_LEN;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, cfg_reconf = 1'b0, cal_ack;
  logic [1:0] cfg_mode = 2'b00;
  logic cal_req, core_wdata, core_oe, pin_wdata, pin_wvalid, pin_rdata, rdata_en;
  logic core_rdata, rdata_valid, done, pass, fail;
  logic [2:0] state_o;
  logic [15:0] err_cnt;

  always #10 clk = ~clk;

  loopback_seq #(.BURSTS(BURSTS), .BURST_LEN(BURST_LEN), .CAL_TIMEOUT(CAL_TIMEOUT)) u_loopback_seq (
    .clk, .rst, .start, .cfg_mode, .cfg_reconf, .cal_req, .cal_ack,
    .core_wdata, .core_oe, .pin_wdata, .pin_wvalid, .pin_rdata, .rdata_en,
    .core_rdata, .rdata_valid, .state_o, .done, .pass, .fail, .err_cnt);

  // PHY model: three-cycle loopback with optional single bit flip
  logic [2:0] wv_p, wd_p, rv_p, rd_p;
  int beat_idx = 0, flip_at = -1, age = 0;
  logic ack_en = 1'b1;
  always_ff @(posedge clk) begin
    if (rst) begin
      wv_p <= '0; wd_p <= '0; rv_p <= '0; rd_p <= '0;
    end else begin
      wv_p <= {wv_p[1:0], core_oe};  wd_p <= {wd_p[1:0], core_wdata};
      rv_p <= {rv_p[1:0], rdata_en}; rd_p <= {rd_p[1:0], pin_rdata};
    end
    age <= cal_req ? age + 1 : 0;
  end
  assign pin_wvalid  = wv_p[2];
  assign pin_wdata   = wd_p[2] ^ (wv_p[2] && beat_idx == flip_at);
  assign rdata_valid = rv_p[2];
  assign core_rdata  = rd_p[2] ^ (rv_p[2] && beat_idx == flip_at);
  assign cal_ack     = ack_en && cal_req && (age >= 5);

  int checks = 0, errors = 0;
  int mask, cal_cyc, oe_cnt, ren_cnt, order_bad;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_vec(input logic [1:0] m, input logic rc, input logic ack, input int flip, input logic mid);
    int prev = 0;
    @(negedge clk);
    cfg_mode = m; cfg_reconf = rc; ack_en = ack; flip_at = flip; beat_idx = 0;
    mask = 0; cal_cyc = 0; oe_cnt = 0; ren_cnt = 0; order_bad = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int c = 0; c < 6000; c++) begin
      if (c != 0) @(negedge clk);
      if (mid && c == 60) begin start = 1'b1; cfg_mode = 2'b00; cfg_reconf = 1'b1; end
      if (mid && c == 61) begin
        start = 1'b0;
        chk("R9 start ignored, phase kept", int'(state_o), 2);
      end
      mask |= (1 << state_o);
      if (int'(state_o) < prev) order_bad = 1;
      prev = int'(state_o);
      if (state_o == 3'd1) cal_cyc++;
      if (core_oe) oe_cnt++;
      if (rdata_en) ren_cnt++;
      if (pin_wvalid || rdata_valid) beat_idx++;
      if (state_o == 3'd4) break;
    end
  endtask

  typedef struct packed {
    logic [1:0] m; logic rc; logic ack; int flip; int mask; logic pass; int err; int cal;
  } vec_t;
  // mask bits: 2 calibration, 4 write, 8 read, 16 finished
  localparam vec_t VECS [8] = '{
    '{2'd0, 1'b0, 1'b1,  -1, 24, 1'b1, 0, 0},
    '{2'd1, 1'b0, 1'b1,  -1, 20, 1'b1, 0, 0},
    '{2'd2, 1'b1, 1'b1,  -1, 30, 1'b1, 0, 0},
    '{2'd2, 1'b1, 1'b0,  -1, 30, 1'b0, 0, CAL_TIMEOUT},
    '{2'd1, 1'b0, 1'b1,  40, 20, 1'b0, 1, 0},
    '{2'd0, 1'b1, 1'b1,  20, 26, 1'b0, 1, 0},
    '{2'd2, 1'b0, 1'b1, 200, 28, 1'b0, 1, 0},
    '{2'd3, 1'b0, 1'b1,  -1, 28, 1'b1, 0, 0}
  };

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R10 reset phase", int'(state_o), 0);
    chk("R10 reset err_cnt", int'(err_cnt), 0);
    chk("R10 reset fail", int'(fail), 0);
    chk("R8 reset done", int'(done), 0);
    chk("R10 reset outputs idle", int'({cal_req, core_oe, rdata_en}), 0);

    for (int i = 0; i < 8; i++) begin
      vec_t v = VECS[i];
      run_vec(v.m, v.rc, v.ack, v.flip, 1'b0);
      chk($sformatf("R1 R2 R3 R4 vec%0d phase set", i), mask, v.mask);
      chk($sformatf("R1 vec%0d order", i), order_bad, 0);
      chk($sformatf("R8 vec%0d done", i), int'(done), 1);
      chk($sformatf("R8 vec%0d pass", i), int'(pass), int'(v.pass));
      chk($sformatf("R6 vec%0d err_cnt", i), int'(err_cnt), v.err);
      chk($sformatf("R6 R7 vec%0d fail", i), int'(fail), int'(!v.pass));
      chk($sformatf("R5 vec%0d write beats", i), oe_cnt, (v.mask & 4) ? BEATS : 0);
      chk($sformatf("R5 vec%0d read beats", i), ren_cnt, (v.mask & 8) ? BEATS : 0);
      if (v.cal != 0) chk($sformatf("R7 vec%0d timeout length", i), cal_cyc, v.cal);
    end

    // R9: a start pulse mid-run with another configuration changes nothing
    run_vec(2'b10, 1'b0, 1'b1, -1, 1'b1);
    chk("R9 phase set after mid-run start", mask, 28);
    chk("R9 write beats", oe_cnt, BEATS);
    chk("R9 pass", int'(pass), 1);

    // R10: reset in the middle of a failing run
    @(negedge clk);
    cfg_mode = 2'b10; cfg_reconf = 1'b0; flip_at = 30; beat_idx = 0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int c = 0; c < 200 && err_cnt == 0; c++) begin
      @(negedge clk);
      if (pin_wvalid || rdata_valid) beat_idx++;
    end
    chk("R6 error seen before reset", int'(err_cnt), 1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R10 mid-run reset phase", int'(state_o), 0);
    chk("R10 mid-run reset err_cnt", int'(err_cnt), 0);
    chk("R10 mid-run reset fail", int'(fail), 0);
    chk("R10 mid-run reset write beat off", int'(core_oe), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule